// File: doc/BRIEF.md
# Write-Packet Header Parser

This block sits behind the serial link's transport layer and takes write-class packets as a 64-bit valid/ready beat stream. Each beat carries start-of-packet, end-of-packet, an empty count and, on the first beat, the packet length in beats. The logical-layer header spans the first two beats. The parser decodes it into a set of held header outputs, including the 29-bit double-word address expanded to a byte address. All later bytes go out as a payload stream with a per-byte valid mask.

The tt field of each packet picks the device-ID width. With 16-bit IDs, every field after the IDs moves 16 bits toward the LSB, so the address splits across the beat boundary at a different point. The four trailing bytes of a packet are a 16-bit CRC and 16 bits of alignment pad. These are stripped from the payload. They may sit wholly in the final beat, or partly in the beat before it.

Back-pressure: a payload beat is held on `out_*` until `out_ready` is seen high. While `out_valid` is high and `out_ready` is low, `in_ready` stays low, and no output changes, the header outputs included. The header outputs take new values only when a packet's second beat is accepted.

Top module: `wr_pkt_hdr_parser`

## Requirements
- R1: After reset, `out_valid` and `bad_pkt` are 0 and `in_ready` is 1.
- R2: From the first beat, prio is read from bits [55:54], tt from [53:52] and ftype from [51:48]. Bits [63:56] are ignored.
- R3: When tt is not 1, the IDs are 8 bits wide. The first beat holds destination [47:40], source [39:32], ttype [31:28], wrsize [27:24], srcTID [23:16] and address bits 28..13 in [15:0]. The second beat holds address bits 12..0 in [63:51], wdptr in [50] and xamsbs in [49:48]. The IDs are presented zero-extended to 16 bits.
- R4: When tt is 1, the first beat holds destination [47:32], source [31:16], ttype [15:12], wrsize [11:8] and srcTID [7:0]. The second beat holds address bits 28..13 in [63:48], bits 12..0 in [47:35], wdptr in [34] and xamsbs in [33:32].
- R5: `hdr_byte_addr` equals the 29-bit double-word address shifted left by three.
- R6: `hdr_nwrite` is 1 exactly when ftype is 5 and ttype is 4.
- R7: Payload beats carry the input beat unchanged in `out_data`. Bit i of `out_keep` marks the byte at bits [8i+7:8i]. The second beat keeps bytes 0..5 (mask 0x3F) for 8-bit IDs and bytes 0..3 (mask 0x0F) for 16-bit IDs. The beats after it keep all eight bytes (0xFF).
- R8: Let v = 8 − empty be the valid bytes of the final beat. If v > 4, that beat is emitted last with only its top v−4 bytes kept. Otherwise it is dropped, and the beat before it is emitted last with its lowest 4−v bytes cleared.
- R9: `out_count` equals the number of set bits in `out_keep`.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and the data, mask, last flag and header outputs hold their values.
- R11: If end-of-packet arrives on the first or second beat, `bad_pkt` pulses for one cycle, no payload is emitted and the header outputs keep their previous values.
- R12: `hdr_beats` gives the size input sampled with start-of-packet. All header outputs change in the cycle after the second beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 64 | Input beat |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Final beat of packet |
| in_empty | input | 3 | Unused low bytes of the final beat |
| in_size | input | SIZE_W | Packet length in beats, valid with in_sop |
| hdr_prio | output | 2 | Priority |
| hdr_tt | output | 2 | Transport type |
| hdr_ftype | output | 4 | Format type |
| hdr_dest_id | output | 16 | Destination ID |
| hdr_src_id | output | 16 | Source ID |
| hdr_ttype | output | 4 | Transaction type |
| hdr_wrsize | output | 4 | Write size code |
| hdr_src_tid | output | 8 | Source transaction ID |
| hdr_byte_addr | output | 32 | Byte address |
| hdr_wdptr | output | 1 | Word pointer |
| hdr_xamsbs | output | 2 | Extended address MSBs |
| hdr_nwrite | output | 1 | Packet is a plain write |
| hdr_beats | output | SIZE_W | Packet length in beats |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Payload beat consumed |
| out_data | output | 64 | Payload beat |
| out_keep | output | 8 | Per-byte valid mask |
| out_count | output | 4 | Number of valid bytes in the beat |
| out_last | output | 1 | Final payload beat |
| bad_pkt | output | 1 | One-cycle pulse on a truncated packet |

## Verification
The bench runs both ID layouts, including a tt value of 2, which must fall back to the narrow layout. A parser that misplaces a field after the IDs would report a wrong ttype, srcTID or address on exactly one layout. The trailer cases cover an empty count of 4, where the final beat is dropped whole, and of 6, where the previous beat must lose its lowest two bytes. A design that strips the trailer only from the final beat would leak the CRC into the payload. Other tests throttle `out_ready` to catch a beat that is lost or changed under back-pressure. They also send one-beat and two-beat packets, which must raise only the error pulse and leave the previous header in place.

// File: rtl/wph_pkg.sv
package wph_pkg;
  localparam int BEAT_W  = 64;
  localparam int KEEP_W  = BEAT_W / 8;
  localparam int EMPTY_W = $clog2(KEEP_W);
  localparam int CNT_W   = $clog2(KEEP_W + 1);

  typedef struct packed {
    logic [1:0]  prio;
    logic [1:0]  tt;
    logic [3:0]  ftype;
    logic [15:0] dest;
    logic [15:0] src;
    logic [3:0]  ttype;
    logic [3:0]  wrsize;
    logic [7:0]  tid;
    logic [31:0] addr;
    logic        wdptr;
    logic [1:0]  xam;
    logic        nwrite;
  } hdr_t;

  function automatic logic [CNT_W-1:0] count_ones(input logic [KEEP_W-1:0] k);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < KEEP_W; i++) c = c + CNT_W'(k[i]);
    return c;
  endfunction
endpackage

// File: rtl/wph_hdr_decode.sv
module wph_hdr_decode
  import wph_pkg::*;
(
  input  logic [55:0]       first,
  input  logic [63:32]      second,
  output hdr_t              hdr,
  output logic [KEEP_W-1:0] lead_keep
);
  logic wide;

  always_comb begin
    wide       = (first[53:52] == 2'b01);
    hdr        = '0;
    hdr.prio   = first[55:54];
    hdr.tt     = first[53:52];
    hdr.ftype  = first[51:48];
    if (wide) begin
      hdr.dest   = first[47:32];
      hdr.src    = first[31:16];
      hdr.ttype  = first[15:12];
      hdr.wrsize = first[11:8];
      hdr.tid    = first[7:0];
      hdr.addr   = {second[63:48], second[47:35], 3'b000};
      hdr.wdptr  = second[34];
      hdr.xam    = second[33:32];
      lead_keep  = KEEP_W'(8'h0F);
    end else begin
      hdr.dest   = {8'h00, first[47:40]};
      hdr.src    = {8'h00, first[39:32]};
      hdr.ttype  = first[31:28];
      hdr.wrsize = first[27:24];
      hdr.tid    = first[23:16];
      hdr.addr   = {first[15:0], second[63:51], 3'b000};
      hdr.wdptr  = second[50];
      hdr.xam    = second[49:48];
      lead_keep  = KEEP_W'(8'h3F);
    end
    hdr.nwrite = (hdr.ftype == 4'd5) && (hdr.ttype == 4'd4);
  end
endmodule

// File: rtl/wph_tail_trim.sv
module wph_tail_trim
  import wph_pkg::*;
#(
  parameter int TRAILER_BYTES = 4
) (
  input  logic [EMPTY_W-1:0] empty,
  input  logic [KEEP_W-1:0]  prev_keep,
  output logic               spill,
  output logic [KEEP_W-1:0]  last_keep,
  output logic [KEEP_W-1:0]  prev_keep_trim
);
  localparam logic [KEEP_W-1:0] ALL = {KEEP_W{1'b1}};

  always_comb begin
    int valid_n;
    valid_n        = KEEP_W - int'(empty);
    spill          = (valid_n > TRAILER_BYTES);
    last_keep      = '0;
    prev_keep_trim = prev_keep;
    if (spill)
      last_keep = ALL << (KEEP_W - (valid_n - TRAILER_BYTES));
    else
      prev_keep_trim = prev_keep & (ALL << (TRAILER_BYTES - valid_n));
  end
endmodule

// File: rtl/wr_pkt_hdr_parser.sv
module wr_pkt_hdr_parser
  import wph_pkg::*;
#(
  parameter int SIZE_W        = 8,
  parameter int TRAILER_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [2:0]        in_empty,
  input  logic [SIZE_W-1:0] in_size,
  output logic [1:0]        hdr_prio,
  output logic [1:0]        hdr_tt,
  output logic [3:0]        hdr_ftype,
  output logic [15:0]       hdr_dest_id,
  output logic [15:0]       hdr_src_id,
  output logic [3:0]        hdr_ttype,
  output logic [3:0]        hdr_wrsize,
  output logic [7:0]        hdr_src_tid,
  output logic [31:0]       hdr_byte_addr,
  output logic              hdr_wdptr,
  output logic [1:0]        hdr_xamsbs,
  output logic              hdr_nwrite,
  output logic [SIZE_W-1:0] hdr_beats,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic [7:0]        out_keep,
  output logic [3:0]        out_count,
  output logic              out_last,
  output logic              bad_pkt
);
  localparam logic [1:0] IDX_FIRST = 2'd0;
  localparam logic [1:0] IDX_SECOND = 2'd1;
  localparam logic [1:0] IDX_BODY = 2'd2;

  logic [1:0]        idx_q;
  logic [55:0]       first_q;
  logic [SIZE_W-1:0] size_stage_q;
  hdr_t              hdr_q;
  logic [SIZE_W-1:0] beats_q;
  logic [BEAT_W-1:0] hold_data;
  logic [KEEP_W-1:0] hold_keep;
  logic              hold_last;
  logic              ov_q, ol_q, bad_q;
  logic [BEAT_W-1:0] od_q;
  logic [KEEP_W-1:0] ok_q;
  logic [CNT_W-1:0]  oc_q;

  hdr_t              dec_hdr;
  logic [KEEP_W-1:0] lead_keep, tail_keep, trim_keep;
  logic              spill;
  logic              out_free, acc, ld, ld_last;
  logic [KEEP_W-1:0] ld_keep;

  wph_hdr_decode u_dec (
    .first(first_q), .second(in_data[63:32]), .hdr(dec_hdr), .lead_keep(lead_keep)
  );

  wph_tail_trim #(.TRAILER_BYTES(TRAILER_BYTES)) u_trim (
    .empty(in_empty), .prev_keep(hold_keep), .spill(spill),
    .last_keep(tail_keep), .prev_keep_trim(trim_keep)
  );

  always_comb begin
    out_free = !ov_q || out_ready;
    in_ready = out_free && !hold_last;
    acc      = in_valid && in_ready;
    ld       = 1'b0;
    ld_last  = 1'b0;
    ld_keep  = hold_keep;
    if (hold_last && out_free) begin
      ld      = 1'b1;
      ld_last = 1'b1;
    end else if (acc && idx_q == IDX_BODY) begin
      ld = 1'b1;
      if (in_eop && !spill) begin
        ld_last = 1'b1;
        ld_keep = trim_keep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q        <= IDX_FIRST;
      first_q      <= '0;
      size_stage_q <= '0;
      hdr_q        <= '0;
      beats_q      <= '0;
      hold_data    <= '0;
      hold_keep    <= '0;
      hold_last    <= 1'b0;
      ov_q         <= 1'b0;
      od_q         <= '0;
      ok_q         <= '0;
      oc_q         <= '0;
      ol_q         <= 1'b0;
      bad_q        <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (ld) begin
        ov_q <= 1'b1;
        od_q <= hold_data;
        ok_q <= ld_keep;
        oc_q <= count_ones(ld_keep);
        ol_q <= ld_last;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
      if (hold_last && out_free) hold_last <= 1'b0;
      if (acc) begin
        if (in_eop) idx_q <= IDX_FIRST;
        else if (idx_q != IDX_BODY) idx_q <= idx_q + 2'd1;
        if (in_eop && idx_q != IDX_BODY) begin
          bad_q <= 1'b1;
        end else begin
          case (idx_q)
            IDX_FIRST: begin
              first_q      <= in_data[55:0];
              size_stage_q <= in_size;
            end
            IDX_SECOND: begin
              hdr_q     <= dec_hdr;
              beats_q   <= size_stage_q;
              hold_data <= in_data;
              hold_keep <= lead_keep;
            end
            default: begin
              if (!in_eop) begin
                hold_data <= in_data;
                hold_keep <= '1;
              end else if (spill) begin
                hold_data <= in_data;
                hold_keep <= tail_keep;
                hold_last <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  assign out_valid     = ov_q;
  assign out_data      = od_q;
  assign out_keep      = ok_q;
  assign out_count     = oc_q;
  assign out_last      = ol_q;
  assign bad_pkt       = bad_q;
  assign hdr_prio      = hdr_q.prio;
  assign hdr_tt        = hdr_q.tt;
  assign hdr_ftype     = hdr_q.ftype;
  assign hdr_dest_id   = hdr_q.dest;
  assign hdr_src_id    = hdr_q.src;
  assign hdr_ttype     = hdr_q.ttype;
  assign hdr_wrsize    = hdr_q.wrsize;
  assign hdr_src_tid   = hdr_q.tid;
  assign hdr_byte_addr = hdr_q.addr;
  assign hdr_wdptr     = hdr_q.wdptr;
  assign hdr_xamsbs    = hdr_q.xam;
  assign hdr_nwrite    = hdr_q.nwrite;
  assign hdr_beats     = beats_q;
endmodule

// File: rtl/wph_parser_chk.sv
module wph_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_eop,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic [7:0]  out_keep,
  input logic        out_last,
  input logic [31:0] hdr_byte_addr,
  input logic        bad_pkt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep)
      && $stable(out_last) && $stable(hdr_byte_addr)); // R10
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_BAD_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pkt |-> $past(in_valid && in_ready && in_eop)); // R11
  AST_BODY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_keep != 8'h00); // R7
endmodule

bind wr_pkt_hdr_parser wph_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eop(in_eop),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
  .out_last(out_last), .hdr_byte_addr(hdr_byte_addr), .bad_pkt(bad_pkt)
);

// File: tb/wr_pkt_hdr_parser_test.sv
module wr_pkt_hdr_parser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0]  in_empty = '0;
  logic [7:0]  in_size = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_last, bad_pkt;
  logic [1:0]  hdr_prio, hdr_tt, hdr_xamsbs;
  logic [3:0]  hdr_ftype, hdr_ttype, hdr_wrsize, out_count;
  logic [15:0] hdr_dest_id, hdr_src_id;
  logic [7:0]  hdr_src_tid, hdr_beats, out_keep;
  logic [31:0] hdr_byte_addr;
  logic        hdr_wdptr, hdr_nwrite;
  logic [63:0] out_data;

  int checks = 0, fails = 0;
  int cap_n = 0, stab_err = 0, bp_err = 0, rcyc = 0;
  bit stall_mode = 0, stall_prev = 0;
  logic [63:0] snap_d;
  logic [7:0]  snap_k;
  logic [63:0] cap_d [16];
  logic [7:0]  cap_k [16];
  logic [3:0]  cap_c [16];
  logic        cap_l [16];
  logic [63:0] exp_d [8];
  logic [7:0]  exp_k [8];
  logic        exp_l [8];

  wr_pkt_hdr_parser uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    rcyc++;
    out_ready = !stall_mode || (rcyc % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev && (!out_valid || out_data !== snap_d || out_keep !== snap_k)) stab_err++;
      if (out_valid && !out_ready && in_ready) bp_err++;
      if (out_valid && out_ready && cap_n < 16) begin
        cap_d[cap_n] = out_data; cap_k[cap_n] = out_keep;
        cap_c[cap_n] = out_count; cap_l[cap_n] = out_last;
        cap_n++;
      end
      stall_prev = out_valid && !out_ready;
      snap_d = out_data; snap_k = out_keep;
    end
  end

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_beat(input logic [63:0] d, input bit sop, input bit eop,
                           input logic [2:0] emp, input logic [7:0] sz);
    bit taken;
    in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop; in_empty = emp; in_size = sz;
    taken = 0;
    while (!taken) begin
      @(negedge clk);
      taken = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic chk_payload(input int n);
    for (int w = 0; w < 200 && !(cap_n >= n && !out_valid); w++) @(posedge clk);
    #1;
    chk("R8", "payload beat total", 64'(cap_n), 64'(n));
    for (int i = 0; i < n; i++) begin
      chk("R7", $sformatf("data beat %0d", i), cap_d[i], exp_d[i]);
      chk("R7", $sformatf("keep beat %0d", i), 64'(cap_k[i]), 64'(exp_k[i]));
      chk("R9", $sformatf("count beat %0d", i), 64'(cap_c[i]), 64'($countones(exp_k[i])));
      chk("R8", $sformatf("last beat %0d", i), 64'(cap_l[i]), 64'(exp_l[i]));
    end
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "bad_pkt", 64'(bad_pkt), 64'd0);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_narrow_example();
    cap_n = 0;
    send_beat(64'h0005_aacc_4c00_5a5a, 1, 0, 0, 8'd5);
    send_beat(64'hcac8_0001_0203_0405, 0, 0, 0, 8'd0);
    send_beat(64'h0607_0809_0a0b_0c0d, 0, 0, 0, 8'd0);
    send_beat(64'h0e0f_1011_1213_1415, 0, 0, 0, 8'd0);
    send_beat(64'hd37c_0000_dead_beef, 0, 1, 3'd4, 8'd0);
    exp_d[0] = 64'hcac8_0001_0203_0405; exp_k[0] = 8'h3F; exp_l[0] = 0;
    exp_d[1] = 64'h0607_0809_0a0b_0c0d; exp_k[1] = 8'hFF; exp_l[1] = 0;
    exp_d[2] = 64'h0e0f_1011_1213_1415; exp_k[2] = 8'hFF; exp_l[2] = 1;
    chk_payload(3);
    chk("R2", "prio", 64'(hdr_prio), 64'd0);
    chk("R2", "ftype", 64'(hdr_ftype), 64'd5);
    chk("R3", "dest", 64'(hdr_dest_id), 64'h00aa);
    chk("R3", "src", 64'(hdr_src_id), 64'h00cc);
    chk("R3", "ttype", 64'(hdr_ttype), 64'd4);
    chk("R3", "wrsize", 64'(hdr_wrsize), 64'hc);
    chk("R3", "srcTID", 64'(hdr_src_tid), 64'h00);
    chk("R5", "byte addr", 64'(hdr_byte_addr), 64'h5a5a_cac8);
    chk("R6", "nwrite", 64'(hdr_nwrite), 64'd1);
    chk("R12", "beats", 64'(hdr_beats), 64'd5);
  endtask

  task automatic t_wide_stalled();
    logic [28:0] a;
    a = 29'h1234567;
    cap_n = 0; bp_err = 0; stab_err = 0; stall_mode = 1;
    send_beat(64'h0095_ccdc_aaba_4b7e, 1, 0, 0, 8'd4);
    send_beat({a[28:13], a[12:0], 1'b1, 2'b11, 32'ha0a1_a2a3}, 0, 0, 0, 8'd0);
    chk("R12", "dest right after second beat", 64'(hdr_dest_id), 64'hccdc);
    send_beat(64'hb0b1_b2b3_b4b5_b6b7, 0, 0, 0, 8'd0);
    send_beat(64'hc0c1_9999_0000_ffff, 0, 1, 3'd2, 8'd0);
    exp_d[0] = {a[28:13], a[12:0], 1'b1, 2'b11, 32'ha0a1_a2a3}; exp_k[0] = 8'h0F; exp_l[0] = 0;
    exp_d[1] = 64'hb0b1_b2b3_b4b5_b6b7; exp_k[1] = 8'hFF; exp_l[1] = 0;
    exp_d[2] = 64'hc0c1_9999_0000_ffff; exp_k[2] = 8'hC0; exp_l[2] = 1;
    chk_payload(3);
    stall_mode = 0;
    chk("R10", "input accepted while stalled", 64'(bp_err), 64'd0);
    chk("R10", "output changed while stalled", 64'(stab_err), 64'd0);
    chk("R2", "prio", 64'(hdr_prio), 64'd2);
    chk("R2", "tt", 64'(hdr_tt), 64'd1);
    chk("R4", "src", 64'(hdr_src_id), 64'haaba);
    chk("R4", "ttype", 64'(hdr_ttype), 64'd4);
    chk("R4", "wrsize", 64'(hdr_wrsize), 64'hb);
    chk("R4", "srcTID", 64'(hdr_src_tid), 64'h7e);
    chk("R4", "wdptr", 64'(hdr_wdptr), 64'd1);
    chk("R4", "xamsbs", 64'(hdr_xamsbs), 64'd3);
    chk("R5", "byte addr", 64'(hdr_byte_addr), 64'({a, 3'b000}));
    chk("R12", "beats", 64'(hdr_beats), 64'd4);
  endtask

  task automatic t_trim_previous();
    cap_n = 0;
    send_beat(64'hf9e5_1122_1d34_0f0f, 1, 0, 0, 8'd4);
    send_beat(64'h001d_5051_5253_5455, 0, 0, 0, 8'd0);
    send_beat(64'h2021_2223_2425_2627, 0, 0, 0, 8'd0);
    send_beat(64'h0000_1111_2222_3333, 0, 1, 3'd6, 8'd0);
    exp_d[0] = 64'h001d_5051_5253_5455; exp_k[0] = 8'h3F; exp_l[0] = 0;
    exp_d[1] = 64'h2021_2223_2425_2627; exp_k[1] = 8'hFC; exp_l[1] = 1;
    chk_payload(2);
    chk("R2", "prio ignores top byte", 64'(hdr_prio), 64'd3);
    chk("R3", "tt=2 narrow dest", 64'(hdr_dest_id), 64'h0011);
    chk("R3", "tt=2 narrow srcTID", 64'(hdr_src_tid), 64'h34);
    chk("R3", "wdptr", 64'(hdr_wdptr), 64'd1);
    chk("R3", "xamsbs", 64'(hdr_xamsbs), 64'd1);
    chk("R5", "byte addr", 64'(hdr_byte_addr), 64'h0f0f_0018);
    chk("R6", "nwrite for ttype 1", 64'(hdr_nwrite), 64'd0);
  endtask

  task automatic t_truncated();
    logic [31:0] a0;
    logic [7:0]  b0;
    a0 = hdr_byte_addr; b0 = hdr_beats; cap_n = 0;
    send_beat(64'h0015_0102_4000_1111, 1, 1, 0, 8'd1);
    chk("R11", "pulse after one-beat packet", 64'(bad_pkt), 64'd1);
    @(posedge clk); #1;
    chk("R11", "pulse length", 64'(bad_pkt), 64'd0);
    send_beat(64'h0015_0304_4000_2222, 1, 0, 0, 8'd2);
    send_beat(64'hffff_0000_0000_0000, 0, 1, 0, 8'd0);
    chk("R11", "pulse after two-beat packet", 64'(bad_pkt), 64'd1);
    repeat (4) @(posedge clk); #1;
    chk("R11", "no payload emitted", 64'(cap_n), 64'd0);
    chk("R11", "addr kept", 64'(hdr_byte_addr), 64'(a0));
    chk("R11", "beats kept", 64'(hdr_beats), 64'(b0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(posedge clk); #1;
    t_narrow_example();
    t_wide_stalled();
    t_trim_previous();
    t_truncated();
    t_narrow_example();
    report();
  end
endmodule